// File: doc/BRIEF.md
# Peripheral Interrupt Flag and Priority Gate

This block is the interrupt front end for one peripheral event source, such as a conversion-complete strobe. Every event pulse latches a sticky pending flag. That latching does not depend on any other setting. Software clears the flag by writing a one to it. Alongside the flag, the block holds an enable bit and a two-bit priority value.

The block compares the priority value with the CPU's present two-bit interrupt mask level. It raises a request when the flag is pending, the enable bit is set, and the priority is strictly greater than that level. While the request is high, the block also drives a fixed exception vector address beside it.

Software reaches the three fields through a small register port. It has a two-bit address, one write strobe, write data, and read data that follows the address with no added cycle. Acknowledge, stacking and arbitration between sources are handled elsewhere.

Top module: `irqg_gate`

## Requirements
- R1: After reset, the pending flag, the enable bit and the priority value are all 0, and `irq_o` is 0.
- R2: A cycle with `evt_i` high sets the pending flag at the next clock edge, whatever the enable bit and priority hold. At address 0, the flag reads back on `rdata_o` bit 0.
- R3: A write to address 0 with `wdata_i` bit 0 equal to 1 clears the flag. A write to address 0 with bit 0 equal to 0 leaves the flag unchanged.
- R4: When `evt_i` is high in the same cycle as a clearing write, the flag ends up set.
- R5: `irq_o` is high exactly when three things hold at once: the flag is set, the enable bit is 1, and the priority value is strictly greater than `cpu_lvl_i`. It follows `cpu_lvl_i` in the same cycle.
- R6: When the enable bit is 0, `irq_o` stays low. The flag keeps its value all the same.
- R7: A priority value of 0 never raises `irq_o`, at any CPU level.
- R8: `vector_o` equals 24'h000024 while `irq_o` is high, and equals 0 otherwise.
- R9: The enable bit is written and read as bit 0 at address 1. The priority is written and read as bits 1:0 at address 2. Address 3 reads 0, and writes to it change no field. Read bits above the fields are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| evt_i | input | 1 | Single-cycle event pulse from the peripheral |
| wr_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address, used for both read and write |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i`, combinational |
| cpu_lvl_i | input | 2 | CPU's current interrupt mask level |
| irq_o | output | 1 | Interrupt request to the CPU |
| vector_o | output | 24 | Exception vector address, valid while `irq_o` is high |

## Verification
The assertions assume `evt_i` and `wr_i` are free of X after reset, and that `cpu_lvl_i` may change in any cycle. The request is combinational from that level, so it is checked only in the same cycle. The flag-hold property assumes no event and no clearing write occurred in the previous cycle, so it is conditioned on both being absent.

The stimulus drives every input at the falling edge so that all values are settled before the rising edge. The random stream draws all four addresses and all CPU levels. It pushes the event rate high enough that flags become pending often, and hits the event-plus-clear collision many times.

// File: rtl/irqg_pkg.sv
package irqg_pkg;

    localparam int DATA_W  = 8;
    localparam int LVL_W   = 2;
    localparam int VEC_W   = 24;
    localparam logic [VEC_W-1:0] VEC_ADDR = 24'h000024;

    typedef enum logic [1:0] {
        RA_FLAG = 2'd0,
        RA_EN   = 2'd1,
        RA_PRIO = 2'd2,
        RA_RSVD = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic             flag;
        logic             en;
        logic [LVL_W-1:0] prio;
    } irq_state_t;

endpackage

// File: rtl/irqg_regs.sv
module irqg_regs
    import irqg_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          evt_i,
    input  logic          wr_i,
    input  logic [1:0]    addr_i,
    input  logic [DW-1:0] wdata_i,
    output irq_state_t    state_o,
    output logic [DW-1:0] rdata_o
);
    irq_state_t st_d, st_q;
    logic       clr_hit;

    always_comb begin
        st_d    = st_q;
        clr_hit = 1'b0;
        if (wr_i) begin
            unique case (reg_addr_e'(addr_i))
                RA_FLAG: clr_hit = wdata_i[0];
                RA_EN:   st_d.en = wdata_i[0];
                RA_PRIO: st_d.prio = wdata_i[LVL_W-1:0];
                default: ;
            endcase
        end
        if (clr_hit) st_d.flag = 1'b0;
        if (evt_i)   st_d.flag = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        rdata_o = '0;
        unique case (reg_addr_e'(addr_i))
            RA_FLAG: rdata_o[0] = st_q.flag;
            RA_EN:   rdata_o[0] = st_q.en;
            RA_PRIO: rdata_o[LVL_W-1:0] = st_q.prio;
            default: ;
        endcase
    end

    assign state_o = st_q;

    AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
        evt_i |=> st_q.flag);                                                   // R2
    AST_FLAG_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && addr_i == 2'd0 && wdata_i[0] && !evt_i) |=> !st_q.flag);       // R3
    AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!evt_i && !(wr_i && addr_i == 2'd0 && wdata_i[0])) |=> $stable(st_q.flag)); // R3
    AST_RSVD_WR: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && addr_i == 2'd3) |=> ($stable(st_q.en) && $stable(st_q.prio)));  // R9
endmodule

// File: rtl/irqg_lvl_cmp.sv
module irqg_lvl_cmp #(
    parameter int W = 2
) (
    input  logic [W-1:0] prio_i,
    input  logic [W-1:0] lvl_i,
    output logic         above_o
);
    assign above_o = (prio_i > lvl_i);

    AST_ZERO_NEVER_ABOVE: assert final ((prio_i != '0) || !above_o);            // R7
endmodule

// File: rtl/irqg_gate.sv
module irqg_gate
    import irqg_pkg::*;
#(
    parameter int                 DW  = DATA_W,
    parameter int                 VW  = VEC_W,
    parameter logic [VEC_W-1:0]   VEC = VEC_ADDR
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          evt_i,
    input  logic          wr_i,
    input  logic [1:0]    addr_i,
    input  logic [DW-1:0] wdata_i,
    output logic [DW-1:0] rdata_o,
    input  logic [LVL_W-1:0] cpu_lvl_i,
    output logic          irq_o,
    output logic [VW-1:0] vector_o
);
    irq_state_t st;
    logic       above;

    irqg_regs #(.DW(DW)) regs_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .evt_i   (evt_i),
        .wr_i    (wr_i),
        .addr_i  (addr_i),
        .wdata_i (wdata_i),
        .state_o (st),
        .rdata_o (rdata_o)
    );

    irqg_lvl_cmp #(.W(LVL_W)) cmp_i (
        .prio_i  (st.prio),
        .lvl_i   (cpu_lvl_i),
        .above_o (above)
    );

    assign irq_o    = st.flag & st.en & above;
    assign vector_o = irq_o ? VW'(VEC) : '0;

    AST_RST_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !irq_o);                                               // R1
    AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (st.en && st.flag));                                          // R6
    AST_IRQ_STRICT: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (st.prio > cpu_lvl_i));                                       // R5
    AST_VEC_WITH_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (vector_o == VW'(VEC)));                                      // R8
    AST_VEC_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_o |-> (vector_o == '0));                                           // R8
endmodule

// File: tb/irqg_gate_tb.sv
module irqg_gate_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        evt_i = 1'b0;
    logic        wr_i = 1'b0;
    logic [1:0]  addr_i = '0;
    logic [7:0]  wdata_i = '0;
    logic [7:0]  rdata_o;
    logic [1:0]  cpu_lvl_i = '0;
    logic        irq_o;
    logic [23:0] vector_o;

    int n_chk = 0;
    int n_bad = 0;
    bit m_flag, m_en;
    logic [1:0] m_prio;

    always #4 clk = ~clk;

    irqg_gate dut_i (
        .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .wr_i(wr_i), .addr_i(addr_i),
        .wdata_i(wdata_i), .rdata_o(rdata_o), .cpu_lvl_i(cpu_lvl_i),
        .irq_o(irq_o), .vector_o(vector_o)
    );

    function automatic logic exp_irq(bit f, bit e, logic [1:0] p, logic [1:0] l);
        return f && e && (p > l);
    endfunction

    function automatic logic [7:0] exp_rd(logic [1:0] a, bit f, bit e, logic [1:0] p);
        case (a)
            2'd0: return {7'd0, f};
            2'd1: return {7'd0, e};
            2'd2: return {6'd0, p};
            default: return 8'd0;
        endcase
    endfunction

    task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic check_outputs(string tag);
        logic ei;
        ei = exp_irq(m_flag, m_en, m_prio, cpu_lvl_i);
        check(irq_o === ei, {tag, " R5 irq"}, irq_o, ei);
        check(vector_o === (ei ? 24'h000024 : 24'h0), {tag, " R8 vector"},
              vector_o, ei ? 24'h000024 : 24'h0);
        check(rdata_o === exp_rd(addr_i, m_flag, m_en, m_prio), {tag, " R9 rdata"},
              rdata_o, exp_rd(addr_i, m_flag, m_en, m_prio));
    endtask

    task automatic model_step();
        if (wr_i) begin
            case (addr_i)
                2'd0: if (wdata_i[0]) m_flag = 1'b0;
                2'd1: m_en = wdata_i[0];
                2'd2: m_prio = wdata_i[1:0];
                default: ;
            endcase
        end
        if (evt_i) m_flag = 1'b1;
    endtask

    task automatic cyc(bit e, bit w, logic [1:0] a, logic [7:0] d, logic [1:0] l, string tag);
        @(negedge clk);
        evt_i = e; wr_i = w; addr_i = a; wdata_i = d; cpu_lvl_i = l;
        #1;
        check_outputs(tag);
        @(posedge clk);
        model_step();
    endtask

    task automatic peek(logic [1:0] a, logic [1:0] l, string tag);
        cyc(1'b0, 1'b0, a, 8'h00, l, tag);
    endtask

    initial begin
        #1_000_000;
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        m_flag = 0; m_en = 0; m_prio = 0;
        repeat (3) @(negedge clk);
        // R1 reset state
        check(irq_o === 1'b0, "R1 irq in reset", irq_o, 0);
        rst_n = 1'b1;
        for (int a = 0; a < 4; a++) peek(a[1:0], 2'd0, "R1 readback after reset");

        // R2 event latches while disabled, prio 0
        cyc(1, 0, 2'd0, 8'h00, 2'd0, "R2 event");
        peek(2'd0, 2'd0, "R2 flag set");
        check(rdata_o[0] === 1'b1, "R2 flag visible", rdata_o[0], 1);

        // R3 write 0 no effect, write 1 clears
        cyc(0, 1, 2'd0, 8'hFE, 2'd0, "R3 write zero");
        peek(2'd0, 2'd0, "R3 after write zero");
        check(rdata_o[0] === 1'b1, "R3 write zero keeps flag", rdata_o[0], 1);
        cyc(0, 1, 2'd0, 8'h01, 2'd0, "R3 clear");
        peek(2'd0, 2'd0, "R3 after clear");
        check(rdata_o[0] === 1'b0, "R3 cleared", rdata_o[0], 0);

        // R4 collision
        cyc(1, 1, 2'd0, 8'h01, 2'd0, "R4 collide");
        peek(2'd0, 2'd0, "R4 after");
        check(rdata_o[0] === 1'b1, "R4 set wins", rdata_o[0], 1);

        // R7 prio 0 with enable at every level
        cyc(0, 1, 2'd1, 8'h01, 2'd0, "R7 enable");
        for (int l = 0; l < 4; l++) begin
            peek(2'd2, l[1:0], "R7 prio zero");
            check(irq_o === 1'b0, "R7 no irq prio zero", irq_o, 0);
        end

        // R5 strict compare with prio 2
        cyc(0, 1, 2'd2, 8'hFE, 2'd0, "R5 prio write");
        for (int l = 0; l < 4; l++) peek(2'd2, l[1:0], "R5 level sweep");
        peek(2'd1, 2'd1, "R5 prio2 lvl1");
        check(irq_o === 1'b1, "R5 irq when above", irq_o, 1);
        peek(2'd1, 2'd2, "R5 prio2 lvl2");
        check(irq_o === 1'b0, "R5 equal blocks", irq_o, 0);

        // R6 disable keeps flag
        cyc(0, 1, 2'd1, 8'h00, 2'd0, "R6 disable");
        peek(2'd0, 2'd0, "R6 disabled");
        check(irq_o === 1'b0 && rdata_o[0] === 1'b1, "R6 suppressed flag kept",
              {irq_o, rdata_o[0]}, 2'b01);

        // R9 reserved address writes
        cyc(0, 1, 2'd3, 8'hFF, 2'd0, "R9 rsvd write");
        peek(2'd1, 2'd0, "R9 en after rsvd");
        check(rdata_o === 8'h00, "R9 en untouched", rdata_o, 0);
        peek(2'd2, 2'd0, "R9 prio after rsvd");
        check(rdata_o === 8'h02, "R9 prio untouched", rdata_o, 2);

        // random phase
        for (int i = 0; i < 3000; i++) begin
            cyc(($urandom % 4) == 0, ($urandom % 3) == 0, 2'($urandom), 8'($urandom),
                2'($urandom), "random");
        end

        // R1 reset mid-run
        @(negedge clk); rst_n = 1'b0; evt_i = 0; wr_i = 0;
        m_flag = 0; m_en = 0; m_prio = 0;
        @(negedge clk); rst_n = 1'b1;
        for (int a = 0; a < 4; a++) peek(a[1:0], 2'd0, "R1 after second reset");

        $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule